// File: doc/BRIEF.md
# Daughterboard GPIO Pin Source Multiplexer

This block controls two banks of general-purpose pins, one for the receive unit and one for the transmit unit. Each bank has a parameterised number of pins, 16 by default. Every pin has its own 2-bit source select. When the pin is an output, the select decides what drives it: a software data register, the automatic transmit/receive (ATR) logic, or one bit of one of two debug buses. A direction register decides for each pin whether its driver is enabled. A read of the data register returns the sampled pin levels after a two-flop synchroniser.

The ATR logic holds four registers: idle, receive-only, transmit-only and full-duplex. The live `rxActive` and `txActive` inputs choose one of them for both units in the same cycle. The direction, data and ATR registers are 32 bits wide and shared by the two units: receive pins sit in the low half and transmit pins in the high half. A write replaces the whole word, so software that changes one unit keeps a shadow copy of the other half. The source selects are held in a separate 32-bit register for each unit.

The pads are outside the block. It presents an output value and an output enable for each pin, and it takes the observed pad level back in.

Top module: `db_pin_mux`

## Requirements
- R1: After reset, `pinOe` and `pinOut` are all zero, and every mapped register reads back zero. This includes all selects (source 0) and the data readback.
- R2: The direction register at byte offset 0x04 maps bit j to pin j. Bits 15:0 are the receive pins 0..15 and bits 31:16 are the transmit pins 0..15. `pinOe[j]` equals that bit, where 1 means output and 0 means input, from the clock edge that accepts the write.
- R3: A pin whose direction bit is 0 has `pinOut` low, whatever its select value is.
- R4: The transmit select register is at offset 0x08 and the receive select register is at offset 0x0C. Pin i of a unit uses bits [2i+1:2i] of its unit's register. The codes are: 0 = software data, 1 = ATR, 2 = debug bus 0, 3 = debug bus 1.
- R5: With source 0, an output pin drives the matching bit of the data register at offset 0x00. A write to it replaces both halves.
- R6: With source 1, an output pin drives the matching bit of the ATR register chosen by {txActive, rxActive}. The choices are: 00 = idle (0x10), 01 = receive-only (0x14), 10 = transmit-only (0x18), 11 = full-duplex (0x1C). The choice follows the inputs without a clock delay.
- R7: With source 2 or 3, an output pin drives bit j of `dbg0` or `dbg1` respectively.
- R8: A read of offset 0x00 returns `pinIn` through two flip-flops. A level that is present at clock edge k is returned after edge k+1 and not before.
- R9: The direction, select and ATR registers read back the last value written to them.
- R10: An access with `busAddr[1:0]` not equal to 0, or with an offset of 0x20 or more, changes no register and reads zero.
- R11: A select write and an ATR state change in the same cycle both take effect. Before the edge, the old select applies to the new ATR state. After the edge, the new select applies.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| busAddr | input | 6 | Byte offset of the register accessed |
| busWrEn | input | 1 | Write strobe for one cycle |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data for `busAddr`, combinational |
| rxActive | input | 1 | Receive activity, selects the ATR register |
| txActive | input | 1 | Transmit activity, selects the ATR register |
| dbg0 | input | 32 | Debug bus 0, one bit per pin |
| dbg1 | input | 32 | Debug bus 1, one bit per pin |
| pinIn | input | 32 | Observed pad levels |
| pinOut | output | 32 | Output value per pin |
| pinOe | output | 32 | Output enable per pin |

## Verification
Two things can land in the same cycle: a write to a receive select register and a change of the ATR activity inputs. The bench provokes this by raising `rxActive` in the same cycle that it presents a write that moves every receive pin from software data to ATR. It then checks `pinOut` before the edge and after it. Before the edge the old software source must still be shown. After the edge the receive-only ATR word must appear. A sweep over many pattern sets then compares every source and every ATR state against an arithmetic model of the pins.

// File: rtl/db_pin_mux_pkg.sv
package db_pin_mux_pkg;

  typedef enum logic [1:0] {
    SRC_SW   = 2'd0,
    SRC_ATR  = 2'd1,
    SRC_DBG0 = 2'd2,
    SRC_DBG1 = 2'd3
  } pinSrc_e;

  // word indices of the register map (byte offset = 4 * index)
  localparam int REG_IO    = 0;
  localparam int REG_DDR   = 1;
  localparam int REG_TXSEL = 2;
  localparam int REG_RXSEL = 3;
  localparam int REG_ATR0  = 4;
  localparam int ATR_CNT   = 4;
  localparam int NUM_REGS  = REG_ATR0 + ATR_CNT;

  typedef struct packed {
    logic               wrIo;
    logic               wrDdr;
    logic               wrTxSel;
    logic               wrRxSel;
    logic [ATR_CNT-1:0] wrAtr;
    logic               rdHit;
    logic [2:0]         rdIdx;
  } pinStrobe_t;

endpackage

// File: rtl/db_pin_mux_ctrl.sv
module db_pin_mux_ctrl
  import db_pin_mux_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  output pinStrobe_t        strobe
);

  localparam int IDX_W = ADDR_W - 2;

  logic             aligned;
  logic [IDX_W-1:0] wordIdx;
  logic             hit;
  logic             wrHit;

  assign aligned = (busAddr[1:0] == 2'b00);
  assign wordIdx = busAddr[ADDR_W-1:2];
  assign hit     = aligned && (wordIdx < IDX_W'(NUM_REGS));
  assign wrHit   = busWrEn && hit;

  assign strobe.wrIo    = wrHit && (wordIdx == IDX_W'(REG_IO));
  assign strobe.wrDdr   = wrHit && (wordIdx == IDX_W'(REG_DDR));
  assign strobe.wrTxSel = wrHit && (wordIdx == IDX_W'(REG_TXSEL));
  assign strobe.wrRxSel = wrHit && (wordIdx == IDX_W'(REG_RXSEL));

  for (genvar k = 0; k < ATR_CNT; k++) begin : g_atrDec
    assign strobe.wrAtr[k] = wrHit && (wordIdx == IDX_W'(REG_ATR0 + k));
  end

  assign strobe.rdHit = hit;
  assign strobe.rdIdx = wordIdx[2:0];

  // R10
  unmapped_no_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && (busAddr[1:0] != 2'b00)) |->
      !(strobe.wrIo || strobe.wrDdr || strobe.wrTxSel || strobe.wrRxSel || (|strobe.wrAtr)));

  // R9
  single_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.wrIo, strobe.wrDdr, strobe.wrTxSel, strobe.wrRxSel, strobe.wrAtr}));

endmodule

// File: rtl/db_pin_mux_dp.sv
module db_pin_mux_dp
  import db_pin_mux_pkg::*;
#(
  parameter int PIN_W = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  pinStrobe_t           strobe,
  input  logic [2*PIN_W-1:0]   wrData,
  input  logic                 rxActive,
  input  logic                 txActive,
  input  logic [2*PIN_W-1:0]   dbg0,
  input  logic [2*PIN_W-1:0]   dbg1,
  input  logic [2*PIN_W-1:0]   pinIn,
  output logic [2*PIN_W-1:0]   pinOut,
  output logic [2*PIN_W-1:0]   pinOe,
  output logic [2*PIN_W-1:0]   rdData
);

  localparam int REG_W = 2 * PIN_W;

  logic [REG_W-1:0] ioReg, ddrReg, txSel, rxSel;
  logic [REG_W-1:0] atrReg [ATR_CNT];
  logic [REG_W-1:0] atrVal;
  logic [2*REG_W-1:0] selAll;
  logic [REG_W-1:0] muxVec;
  logic [REG_W-1:0] syncA, syncB;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ioReg  <= '0;
      ddrReg <= '0;
      txSel  <= '0;
      rxSel  <= '0;
    end else begin
      if (strobe.wrIo)    ioReg  <= wrData;
      if (strobe.wrDdr)   ddrReg <= wrData;
      if (strobe.wrTxSel) txSel  <= wrData;
      if (strobe.wrRxSel) rxSel  <= wrData;
    end
  end

  for (genvar k = 0; k < ATR_CNT; k++) begin : g_atr
    always_ff @(posedge clk) begin
      if (!rstN)                atrReg[k] <= '0;
      else if (strobe.wrAtr[k]) atrReg[k] <= wrData;
    end
  end

  // ATR state: bit1 = transmit active, bit0 = receive active
  assign atrVal = atrReg[{txActive, rxActive}];

  // receive fields occupy the low word, transmit fields the high word
  assign selAll = {txSel, rxSel};

  for (genvar j = 0; j < REG_W; j++) begin : g_pin
    pinSrc_e src;
    assign src = pinSrc_e'(selAll[2*j +: 2]);
    assign muxVec[j] = (src == SRC_SW)   ? ioReg[j]  :
                       (src == SRC_ATR)  ? atrVal[j] :
                       (src == SRC_DBG0) ? dbg0[j]   : dbg1[j];
  end

  assign pinOe  = ddrReg;
  assign pinOut = ddrReg & muxVec;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncA <= '0;
      syncB <= '0;
    end else begin
      syncA <= pinIn;
      syncB <= syncA;
    end
  end

  always_comb begin
    rdData = '0;
    if (strobe.rdHit) begin
      case (strobe.rdIdx)
        3'(REG_IO):    rdData = syncB;
        3'(REG_DDR):   rdData = ddrReg;
        3'(REG_TXSEL): rdData = txSel;
        3'(REG_RXSEL): rdData = rxSel;
        default:       rdData = atrReg[strobe.rdIdx[1:0]];
      endcase
    end
  end

  // cycles since reset, saturating, for the synchroniser check
  logic [1:0] syncAge;
  always_ff @(posedge clk) begin
    if (!rstN)              syncAge <= '0;
    else if (syncAge != 2'd2) syncAge <= syncAge + 2'd1;
  end

  // R2
  ddr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.wrDdr |=> $stable(pinOe));

  // R9
  sel_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.wrTxSel || strobe.wrRxSel) |=> $stable(selAll));

  // R8
  sync_delay_chk: assert property (@(posedge clk) disable iff (!rstN)
    (syncAge == 2'd2) |-> (syncB == $past(pinIn, 2)));

endmodule

// File: rtl/db_pin_mux.sv
module db_pin_mux
  import db_pin_mux_pkg::*;
#(
  parameter int PIN_W  = 16,
  parameter int ADDR_W = 6
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic                 busWrEn,
  input  logic [2*PIN_W-1:0]   busWrData,
  output logic [2*PIN_W-1:0]   busRdData,
  input  logic                 rxActive,
  input  logic                 txActive,
  input  logic [2*PIN_W-1:0]   dbg0,
  input  logic [2*PIN_W-1:0]   dbg1,
  input  logic [2*PIN_W-1:0]   pinIn,
  output logic [2*PIN_W-1:0]   pinOut,
  output logic [2*PIN_W-1:0]   pinOe
);

  pinStrobe_t strobe;

  db_pin_mux_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .busAddr (busAddr),
    .busWrEn (busWrEn),
    .strobe  (strobe)
  );

  db_pin_mux_dp #(.PIN_W(PIN_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .wrData   (busWrData),
    .rxActive (rxActive),
    .txActive (txActive),
    .dbg0     (dbg0),
    .dbg1     (dbg1),
    .pinIn    (pinIn),
    .pinOut   (pinOut),
    .pinOe    (pinOe),
    .rdData   (busRdData)
  );

endmodule

// File: tb/db_pin_mux_tb.sv
module db_pin_mux_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [5:0]  busAddr = '0;
  logic        busWrEn = 1'b0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic        rxActive = 1'b0;
  logic        txActive = 1'b0;
  logic [31:0] dbg0 = '0;
  logic [31:0] dbg1 = '0;
  logic [31:0] extDrive = '0;
  logic [31:0] pinIn;
  logic [31:0] pinOut;
  logic [31:0] pinOe;

  int nChecks = 0;
  int nBad = 0;
  bit finished = 0;
  logic [31:0] seed = 32'h1234_5678;

  always #10 clk = ~clk;

  // pad model: driven pins read back their own value
  assign pinIn = (pinOut & pinOe) | (extDrive & ~pinOe);

  db_pin_mux u_dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData), .rxActive(rxActive),
    .txActive(txActive), .dbg0(dbg0), .dbg1(dbg1), .pinIn(pinIn),
    .pinOut(pinOut), .pinOe(pinOe)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] nextRand();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 17);
    seed = seed ^ (seed << 5);
    return seed;
  endfunction

  task automatic regWrite(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic regRead(input logic [5:0] a, output logic [31:0] d);
    busAddr = a;
    #1 d = busRdData;
  endtask

  // expected pins from the requirement text: unit split, 2-bit fields
  function automatic logic [31:0] expPins(input logic [31:0] ddr, io, rxs, txs, atrv, d0, d1);
    logic [31:0] r = '0;
    for (int j = 0; j < 32; j++) begin
      logic [1:0] s;
      logic b;
      s = (j < 16) ? rxs[2*j +: 2] : txs[2*(j-16) +: 2];
      case (s)
        2'd0: b = io[j];
        2'd1: b = atrv[j];
        2'd2: b = d0[j];
        default: b = d1[j];
      endcase
      r[j] = ddr[j] & b;
    end
    return r;
  endfunction

  logic [31:0] rd;
  logic [31:0] atrM [4];
  logic [31:0] ddrM, ioM, rxsM, txsM;

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      nBad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", nChecks, nBad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 pinOe after reset", pinOe, 32'h0);
    check("R1 pinOut after reset", pinOut, 32'h0);
    for (int i = 0; i < 8; i++) begin
      regRead(6'(4*i), rd);
      check("R1 register read after reset", rd, 32'h0);
    end

    // R9 readback of every stored register
    for (int i = 1; i < 8; i++) begin
      logic [31:0] v;
      v = nextRand();
      regWrite(6'(4*i), v);
      regRead(6'(4*i), rd);
      check("R9 readback", rd, v);
      if (i >= 4) atrM[i-4] = v;
    end
    regRead(6'h04, ddrM);
    regRead(6'h08, txsM);
    regRead(6'h0C, rxsM);

    // R10 misaligned and out-of-range writes ignored, read zero
    regWrite(6'h05, 32'hDEAD_BEEF);
    regWrite(6'h20, 32'hDEAD_BEEF);
    regWrite(6'h3C, 32'hDEAD_BEEF);
    regRead(6'h04, rd);
    check("R10 ddr unchanged", rd, ddrM);
    check("R10 pinOe unchanged", pinOe, ddrM);
    regRead(6'h08, rd);
    check("R10 txsel unchanged", rd, txsM);
    regRead(6'h20, rd);
    check("R10 out-of-range read", rd, 32'h0);
    regRead(6'h05, rd);
    check("R10 misaligned read", rd, 32'h0);

    // R3 inputs stay low whatever the select
    regWrite(6'h04, 32'h0);
    regWrite(6'h00, 32'hFFFF_FFFF);
    regWrite(6'h08, 32'h0);
    regWrite(6'h0C, 32'hFFFF_FFFF);
    dbg0 = '1; dbg1 = '1;
    @(negedge clk);
    check("R3 pinOut with all inputs", pinOut, 32'h0);
    check("R3 pinOe with all inputs", pinOe, 32'h0);

    // R2 R5 software data, split halves
    regWrite(6'h0C, 32'h0);
    regWrite(6'h04, 32'hFFFF_0F0F);
    check("R2 pinOe follows direction", pinOe, 32'hFFFF_0F0F);
    regWrite(6'h00, 32'hA5C3_3C5A);
    check("R5 software data", pinOut, 32'hA5C3_3C5A & 32'hFFFF_0F0F);
    regWrite(6'h00, 32'h0000_FFFF);
    check("R5 whole-word replace", pinOut, 32'h0000_0F0F);

    // R4 R6 R7 sweep over random configurations and all ATR states
    for (int it = 0; it < 64; it++) begin
      ddrM = nextRand(); ioM = nextRand(); rxsM = nextRand(); txsM = nextRand();
      if (it == 0) begin rxsM = 32'h5555_5555; txsM = 32'h5555_5555; end
      if (it == 1) begin rxsM = 32'hAAAA_AAAA; txsM = 32'hFFFF_FFFF; end
      regWrite(6'h04, ddrM);
      regWrite(6'h00, ioM);
      regWrite(6'h0C, rxsM);
      regWrite(6'h08, txsM);
      for (int k = 0; k < 4; k++) begin
        atrM[k] = nextRand();
        regWrite(6'(16 + 4*k), atrM[k]);
      end
      dbg0 = nextRand(); dbg1 = nextRand();
      for (int st = 0; st < 4; st++) begin
        @(negedge clk);
        {txActive, rxActive} = 2'(st);
        #1;
        check("R4 R6 R7 pin source", pinOut,
              expPins(ddrM, ioM, rxsM, txsM, atrM[st], dbg0, dbg1));
      end
    end

    // R8 two-flop readback of input levels
    regWrite(6'h04, 32'h0);
    extDrive = 32'h1357_9BDF;
    repeat (3) @(negedge clk);
    regRead(6'h00, rd);
    check("R8 settled input readback", rd, 32'h1357_9BDF);
    extDrive = 32'hFEDC_0123;
    @(negedge clk);
    regRead(6'h00, rd);
    check("R8 not visible after one edge", rd, 32'h1357_9BDF);
    @(negedge clk);
    regRead(6'h00, rd);
    check("R8 visible after two edges", rd, 32'hFEDC_0123);
    regWrite(6'h04, 32'hFFFF_0000);
    regWrite(6'h08, 32'h0);
    regWrite(6'h00, 32'h8421_0000);
    repeat (2) @(negedge clk);
    regRead(6'h00, rd);
    check("R8 mixed output/input readback", rd, 32'h8421_0123);

    // R11 select write and ATR change in the same cycle
    regWrite(6'h04, 32'h0000_FFFF);
    regWrite(6'h00, 32'h0000_1234);
    regWrite(6'h0C, 32'h0);
    regWrite(6'h14, 32'h0000_C3A5);
    regWrite(6'h10, 32'h0000_0000);
    {txActive, rxActive} = 2'b00;
    @(negedge clk);
    busAddr = 6'h0C; busWrData = 32'h5555_5555; busWrEn = 1'b1;
    rxActive = 1'b1;
    #1;
    check("R11 before edge old select", pinOut, 32'h0000_1234);
    @(negedge clk);
    busWrEn = 1'b0;
    check("R11 after edge new select and state", pinOut, 32'h0000_C3A5);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", nChecks, nBad);
    $finish;
  end

endmodule